// File: doc/BRIEF.md
# Instruction-Cycle Sequencer for an Accumulator Machine

This block is the hardwired control and datapath of a small accumulator machine with a single memory port. It moves through four major cycles: fetch, indirect, execute and interrupt. Each cycle is a fixed sequence of single-clock steps. Each step issues a handful of register-transfer strobes among the address register, the buffer register, the program counter, the instruction register and the accumulator `R1`. The strobes follow two rules: no register or bus is used twice in one step, and every data dependency is kept in order.

Memory is synchronous. A read strobe issued in one clock gives its data in the next clock, so every read is followed by a capture step before the word is used. A write happens at the clock edge that ends the step carrying the write strobe. The instruction word is 16 bits wide. Bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. Opcode 1 adds a memory word into `R1`. Opcode 2 increments a memory word and skips the next instruction when the result is zero. Opcode 3 saves the return address and branches. Every other opcode executes as a one-clock no-op.

Top module: `cycle_ctrl_unit`

## Requirements
- R1: While reset is high, PC, IR and R1 read zero and the cycle code reads 00 (fetch); interrupts become enabled.
- R2: Fetch lasts 4 clocks. It loads IR with the word at PC, and PC increments in its second clock.
- R3: The cycle code is 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. After fetch comes indirect when bit 15 of the fetched word is set, and execute otherwise. Indirect is always followed by execute, and interrupt by fetch.
- R4: Indirect lasts 4 clocks. It reads the word at IR[11:0] and replaces IR[11:0] with that word's low 12 bits. IR[15:12] is unchanged.
- R5: Opcode 1 lasts 4 clocks in execute and sets R1 to R1 plus the word at the operand address, modulo 2^16.
- R6: Opcode 2 lasts 5 clocks in execute. In its fifth clock it writes the operand word plus one back to the operand address. When that value is zero, PC increments once more.
- R7: Opcode 3 lasts 3 clocks in execute. It writes the current PC, zero-extended, to the operand address in its second clock, and leaves PC at operand address plus one.
- R8: Any other opcode lasts 1 clock in execute and changes no register and no memory word.
- R9: At the end of execute, a high `irqReq` with interrupts enabled selects the interrupt cycle and disables interrupts until reset. The interrupt cycle lasts 3 clocks: it writes PC to address 0x000 in its third clock and sets PC to 0x001.
- R10: Read and write strobes are never high together. Whenever either is high, `memAddr` carries the address register. `memWData` carries the buffer register during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irqReq | input | 1 | Interrupt request level, sampled at the end of execute |
| memAddr | output | 12 | Memory address (address register) |
| memRead | output | 1 | Read strobe; data is expected on `memRData` one clock later |
| memWrite | output | 1 | Write strobe; memory stores `memWData` at the clock edge |
| memWData | output | 16 | Write data (buffer register) |
| memRData | input | 16 | Read data returned by the memory |
| cycleCode | output | 2 | Current major cycle code |
| pcOut | output | 12 | Program counter |
| irOut | output | 16 | Instruction register |
| r1Out | output | 16 | Accumulator R1 |

## Verification
Every register transfer lands at the rising edge that ends its step. A change requested in step k of a cycle is therefore visible from the clock after that step, and a read strobe's data is consumed one step after the strobe. The bench keeps a behavioural model that advances at the same rising edges. The model tracks cycle, step and a private memory image. The bench compares the cycle code, PC, IR, R1 and both strobes against the model at every falling edge, half a clock after each update. At the end of the run it compares the memory words touched by the skip, save-and-branch and interrupt sequences against the model's image.

// File: rtl/cuc_pkg.sv
package cuc_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_INDIR = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INTR  = 2'b11
  } cycle_e;

  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_ISZ = 3'd2;
  localparam logic [2:0] OP_BSA = 3'd3;

  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic marFromSave;
    logic mbrFromMem;
    logic mbrFromPc;
    logic mbrInc;
    logic irFromMbr;
    logic irAddrFromMbr;
    logic pcInc;
    logic pcFromIr;
    logic pcFromVec;
    logic pcSkipZero;
    logic r1Add;
    logic memRd;
    logic memWr;
  } uop_t;

endpackage

// File: rtl/cuc_seq.sv
module cuc_seq
  import cuc_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mbrInd,
  input  logic [OPC_W-1:0] irOpcode,
  input  logic             irqReq,
  output uop_t             uop,
  output cycle_e           cycle
);

  logic [STEP_W-1:0] step;
  logic              lastStep;
  logic              intEn;
  cycle_e            nextCycle;

  always_comb begin
    uop      = '0;
    lastStep = 1'b0;
    unique case (cycle)
      CYC_FETCH: begin
        case (step)
          STEP_W'(0): uop.marFromPc = 1'b1;
          STEP_W'(1): begin uop.memRd = 1'b1; uop.pcInc = 1'b1; end
          STEP_W'(2): uop.mbrFromMem = 1'b1;
          default:    begin uop.irFromMbr = 1'b1; lastStep = 1'b1; end
        endcase
      end
      CYC_INDIR: begin
        case (step)
          STEP_W'(0): uop.marFromIr = 1'b1;
          STEP_W'(1): uop.memRd = 1'b1;
          STEP_W'(2): uop.mbrFromMem = 1'b1;
          default:    begin uop.irAddrFromMbr = 1'b1; lastStep = 1'b1; end
        endcase
      end
      CYC_EXEC: begin
        if (irOpcode == OP_ADD) begin
          case (step)
            STEP_W'(0): uop.marFromIr = 1'b1;
            STEP_W'(1): uop.memRd = 1'b1;
            STEP_W'(2): uop.mbrFromMem = 1'b1;
            default:    begin uop.r1Add = 1'b1; lastStep = 1'b1; end
          endcase
        end else if (irOpcode == OP_ISZ) begin
          case (step)
            STEP_W'(0): uop.marFromIr = 1'b1;
            STEP_W'(1): uop.memRd = 1'b1;
            STEP_W'(2): uop.mbrFromMem = 1'b1;
            STEP_W'(3): uop.mbrInc = 1'b1;
            default:    begin uop.memWr = 1'b1; uop.pcSkipZero = 1'b1; lastStep = 1'b1; end
          endcase
        end else if (irOpcode == OP_BSA) begin
          case (step)
            STEP_W'(0): begin uop.marFromIr = 1'b1; uop.mbrFromPc = 1'b1; end
            STEP_W'(1): begin uop.pcFromIr = 1'b1; uop.memWr = 1'b1; end
            default:    begin uop.pcInc = 1'b1; lastStep = 1'b1; end
          endcase
        end else begin
          lastStep = 1'b1;
        end
      end
      default: begin
        case (step)
          STEP_W'(0): uop.mbrFromPc = 1'b1;
          STEP_W'(1): begin uop.marFromSave = 1'b1; uop.pcFromVec = 1'b1; end
          default:    begin uop.memWr = 1'b1; lastStep = 1'b1; end
        endcase
      end
    endcase
  end

  always_comb begin
    unique case (cycle)
      CYC_FETCH: nextCycle = mbrInd ? CYC_INDIR : CYC_EXEC;
      CYC_INDIR: nextCycle = CYC_EXEC;
      CYC_EXEC:  nextCycle = (irqReq && intEn) ? CYC_INTR : CYC_FETCH;
      default:   nextCycle = CYC_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle <= CYC_FETCH;
      step  <= '0;
      intEn <= 1'b1;
    end else if (lastStep) begin
      cycle <= nextCycle;
      step  <= '0;
      if (nextCycle == CYC_INTR) intEn <= 1'b0;
    end else begin
      step <= step + 1'b1;
    end
  end

endmodule

// File: rtl/cuc_dpath.sv
module cuc_dpath
  import cuc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OPC_W     = 3,
  parameter int ADDR_W    = 12,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  uop_t              uop,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] r1,
  output logic              mbrInd,
  output logic [OPC_W-1:0]  irOpcode
);

  localparam int PAD_W = DATA_W - ADDR_W;

  assign mbrInd   = mbr[DATA_W-1];
  assign irOpcode = ir[DATA_W-2 -: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mbr <= '0;
      pc  <= '0;
      ir  <= '0;
      r1  <= '0;
    end else begin
      if (uop.marFromPc)        mar <= pc;
      else if (uop.marFromIr)   mar <= ir[ADDR_W-1:0];
      else if (uop.marFromSave) mar <= ADDR_W'(SAVE_ADDR);

      if (uop.mbrFromMem)      mbr <= memRData;
      else if (uop.mbrFromPc)  mbr <= {{PAD_W{1'b0}}, pc};
      else if (uop.mbrInc)     mbr <= mbr + 1'b1;

      if (uop.irFromMbr)          ir <= mbr;
      else if (uop.irAddrFromMbr) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];

      if (uop.pcFromIr)       pc <= ir[ADDR_W-1:0];
      else if (uop.pcFromVec) pc <= ADDR_W'(VEC_ADDR);
      else if (uop.pcInc)     pc <= pc + 1'b1;
      else if (uop.pcSkipZero && (mbr == '0)) pc <= pc + 1'b1;

      if (uop.r1Add) r1 <= r1 + mbr;
    end
  end

endmodule

// File: rtl/cycle_ctrl_unit.sv
module cycle_ctrl_unit
  import cuc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OPC_W     = 3,
  parameter int ADDR_W    = DATA_W - OPC_W - 1,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irqReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [1:0]        cycleCode,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] irOut,
  output logic [DATA_W-1:0] r1Out
);

  uop_t              uop;
  cycle_e            cycle;
  logic              mbrInd;
  logic [OPC_W-1:0]  irOpcode;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;

  cuc_seq #(.OPC_W(OPC_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .mbrInd   (mbrInd),
    .irOpcode (irOpcode),
    .irqReq   (irqReq),
    .uop      (uop),
    .cycle    (cycle)
  );

  cuc_dpath #(
    .DATA_W    (DATA_W),
    .OPC_W     (OPC_W),
    .ADDR_W    (ADDR_W),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .uop      (uop),
    .memRData (memRData),
    .mar      (mar),
    .mbr      (mbr),
    .pc       (pcOut),
    .ir       (irOut),
    .r1       (r1Out),
    .mbrInd   (mbrInd),
    .irOpcode (irOpcode)
  );

  assign memAddr   = mar;
  assign memWData  = mbr;
  assign memRead   = uop.memRd;
  assign memWrite  = uop.memWr;
  assign cycleCode = cycle;

endmodule

// File: rtl/cuc_checker.sv
module cuc_checker #(
  parameter int ADDR_W   = 12,
  parameter int VEC_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cycleCode,
  input logic [ADDR_W-1:0] pcOut,
  input logic              memRead,
  input logic              memWrite
);

  // R1: the first clock after reset still shows the fetch code and PC at zero
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cycleCode == 2'b00 && pcOut == '0));

  // R10: strobes are exclusive
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  // R3: fetch hands over only to indirect or execute
  a_r3_fetch_next: assert property (@(posedge clk) disable iff (rst)
    ($past(cycleCode) == 2'b00 && cycleCode != 2'b00) |-> (cycleCode == 2'b01 || cycleCode == 2'b10));

  // R3: indirect hands over only to execute
  a_r3_indir_next: assert property (@(posedge clk) disable iff (rst)
    ($past(cycleCode) == 2'b01 && cycleCode != 2'b01) |-> cycleCode == 2'b10);

  // R9: interrupt is entered only from execute
  a_r9_intr_entry: assert property (@(posedge clk) disable iff (rst)
    (cycleCode == 2'b11 && $past(cycleCode) != 2'b11) |-> $past(cycleCode) == 2'b10);

  // R9: leaving interrupt lands on the service routine address
  a_r9_intr_vector: assert property (@(posedge clk) disable iff (rst)
    ($past(cycleCode) == 2'b11 && cycleCode == 2'b00) |-> pcOut == ADDR_W'(VEC_ADDR));

endmodule

bind cycle_ctrl_unit cuc_checker #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cycleCode (cycleCode),
  .pcOut     (pcOut),
  .memRead   (memRead),
  .memWrite  (memWrite)
);

// File: tb/tb_cycle_ctrl_unit.sv
module tb_cycle_ctrl_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [11:0] memAddr;
  logic        memRead, memWrite;
  logic [15:0] memWData;
  logic [15:0] memRData;
  logic [1:0]  cycleCode;
  logic [11:0] pcOut;
  logic [15:0] irOut, r1Out;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  cycle_ctrl_unit dut (
    .clk(clk), .rst(rst), .irqReq(irq),
    .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite),
    .memWData(memWData), .memRData(memRData),
    .cycleCode(cycleCode), .pcOut(pcOut), .irOut(irOut), .r1Out(r1Out)
  );

  // program image: instruction = {ind, opcode[2:0], addr[11:0]}
  function automatic logic [15:0] initWord(int a);
    case (a)
      'h000: return 16'h3010;  // save-and-branch to 0x010
      'h001: return 16'h1100;  // service routine: add [0x100]
      'h011: return 16'h1100;  // add [0x100]
      'h012: return 16'h9101;  // add indirect via 0x101
      'h013: return 16'h2103;  // increment-skip 0x103
      'h014: return 16'h2103;  // increment-skip 0x103 (hits zero)
      'h015: return 16'h1100;  // skipped
      'h016: return 16'h7000;  // unused opcode
      'h017: return 16'hA104;  // increment-skip indirect via 0x104
      'h100: return 16'h0005;
      'h101: return 16'h0102;
      'h102: return 16'h0007;
      'h103: return 16'hFFFE;
      'h104: return 16'h0105;
      'h105: return 16'h0003;
      default: return 16'h0000;
    endcase
  endfunction

  // memory seen by the design
  logic [15:0] ram [0:511];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) ram[i] <= initWord(i);
    end else begin
      if (memWrite) ram[memAddr[8:0]] <= memWData;
      if (memRead)  memRData <= ram[memAddr[8:0]];
    end
  end

  // behavioural reference model
  int mCyc, mStep, mPc, mIr, mR1, mMar, mMbr, mIen;
  int mm [0:511];

  function automatic int opOf(int w);
    return (w >> 12) & 7;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCyc = 0; mStep = 0; mPc = 0; mIr = 0; mR1 = 0; mMar = 0; mMbr = 0; mIen = 1;
      for (int i = 0; i < 512; i++) mm[i] = initWord(i);
    end else begin
      bit fin;
      int nxt;
      fin = 0; nxt = 0;
      case (mCyc)
        0: case (mStep)
             0: mMar = mPc;
             1: mPc = (mPc + 1) & 'hFFF;
             2: mMbr = mm[mMar & 511];
             default: begin mIr = mMbr; fin = 1; nxt = (mIr & 'h8000) ? 1 : 2; end
           endcase
        1: case (mStep)
             0: mMar = mIr & 'hFFF;
             1: ;
             2: mMbr = mm[mMar & 511];
             default: begin mIr = (mIr & 'hF000) | (mMbr & 'hFFF); fin = 1; nxt = 2; end
           endcase
        2: begin
             case (opOf(mIr))
               1: case (mStep)
                    0: mMar = mIr & 'hFFF;
                    1: ;
                    2: mMbr = mm[mMar & 511];
                    default: begin mR1 = (mR1 + mMbr) & 'hFFFF; fin = 1; end
                  endcase
               2: case (mStep)
                    0: mMar = mIr & 'hFFF;
                    1: ;
                    2: mMbr = mm[mMar & 511];
                    3: mMbr = (mMbr + 1) & 'hFFFF;
                    default: begin
                      mm[mMar & 511] = mMbr;
                      if (mMbr == 0) mPc = (mPc + 1) & 'hFFF;
                      fin = 1;
                    end
                  endcase
               3: case (mStep)
                    0: begin mMar = mIr & 'hFFF; mMbr = mPc; end
                    1: begin mPc = mIr & 'hFFF; mm[mMar & 511] = mMbr; end
                    default: begin mPc = (mPc + 1) & 'hFFF; fin = 1; end
                  endcase
               default: fin = 1;
             endcase
             if (fin) begin
               if (irq && mIen != 0) begin nxt = 3; mIen = 0; end
               else nxt = 0;
             end
           end
        default: case (mStep)
             0: mMbr = mPc;
             1: begin mMar = 0; mPc = 1; end
             default: begin mm[mMar & 511] = mMbr; fin = 1; nxt = 0; end
           endcase
      endcase
      if (fin) begin mCyc = nxt; mStep = 0; end
      else mStep = mStep + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string ctxTag();
    case (mCyc)
      0: return "R2";
      1: return "R4";
      3: return "R9";
      default: case (opOf(mIr))
        1: return "R5";
        2: return "R6";
        3: return "R7";
        default: return "R8";
      endcase
    endcase
  endfunction

  bit running = 0;
  always @(negedge clk) begin
    if (running && !rst) begin
      int expRd, expWr, op;
      string t;
      t  = ctxTag();
      op = opOf(mIr);
      expWr = ((mCyc == 3 && mStep == 2) || (mCyc == 2 && op == 2 && mStep == 4) ||
               (mCyc == 2 && op == 3 && mStep == 1)) ? 1 : 0;
      expRd = (mStep == 1 && (mCyc == 0 || mCyc == 1 || (mCyc == 2 && (op == 1 || op == 2)))) ? 1 : 0;
      chk("R3 cycle code", int'(cycleCode), mCyc);
      chk({t, " pc"}, int'(pcOut), mPc);
      chk({t, " ir"}, int'(irOut), mIr);
      chk({t, " r1"}, int'(r1Out), mR1);
      chk("R10 read strobe", int'(memRead), expRd);
      chk("R10 write strobe", int'(memWrite), expWr);
      if (memRead || memWrite) chk("R10 address", int'(memAddr), mMar);
      if (memWrite) chk({t, " R10 write data"}, int'(memWData), mMbr);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc", int'(pcOut), 0);
    chk("R1 ir", int'(irOut), 0);
    chk("R1 r1", int'(r1Out), 0);
    chk("R1 cycle", int'(cycleCode), 0);
    rst = 1'b0;
    running = 1;
    repeat (150) @(negedge clk);
    irq = 1'b1;                    // R9: request held high, taken once
    repeat (650) @(negedge clk);
    running = 0;
    chk("R7 saved return word", int'(ram['h010]), mm['h010]);
    chk("R7 saved return value", int'(ram['h010]), 1);
    chk("R6 counter word", int'(ram['h103]), mm['h103]);
    chk("R6 indirect counter", int'(ram['h105]), mm['h105]);
    chk("R9 saved pc", int'(ram['h000]), mm['h000]);
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) if (int'(ram[i]) != mm[i]) bad++;
      chk("R8 memory image mismatches", bad, 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule